// File: doc/BRIEF.md
# Serial Configuration Memory Word Reader with Address-Width Discovery

This block is a master for a three-wire-plus-select serial configuration memory of the 93-series kind. The host places a word address on `word_addr` and pulses `start`. The block then frames one read transaction on the serial lines and shifts in a 16-bit word. It returns that word on `rd_data` together with a one-cycle `done` pulse. Each transaction raises chip select and sends a three-bit read command. It then sends the address bits most significant first and clocks in the data bits most significant first. At the end it drops every serial line to zero.

The address width of the attached device is not a parameter. It is learned on the first read after reset. On that probing read the block sends zero address bits, up to `MAX_AW` of them. After each bit it looks at the device's data line. The device drives a dummy zero once it has received its full address, and the number of bits sent up to that point is the device's address width. The data of the probing read is discarded. The block then performs the host's read with the learned width, all within the same busy window. It reports the width on `addr_width` and `size_known`. The device holds 2^width words, and all later reads send exactly that many address bits.

The serial clock speed is set by `half_div`. This is the length in system cycles of each of the three phases that make up one serial bit. Values below the minimum are raised to the minimum.

Top module: `uwire_rom_reader`

## Requirements
- R1: While reset is asserted and right after it, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `size_known` are 0 and `addr_width` is 0.
- R2: A transaction opens with one phase in which `ee_cs` is 1 and `ee_sk` and `ee_di` are 0. It then sends the command bits 1, 1, 0 in that order. `ee_cs` is 1 only while `busy` is 1, and when `ee_cs` falls, `ee_sk` and `ee_di` are both 0.
- R3: Every serial bit takes three phases: `ee_di` is set with `ee_sk` low, `ee_sk` is high for one phase, and `ee_sk` is low for one more phase. `ee_di` does not change while `ee_sk` is high, and `ee_sk` is high only while `ee_cs` is 1.
- R4: The first read after reset is a probe that sends 0-valued address bits. It stops after the first bit at whose end `ee_do` is sampled low, or after `MAX_AW` bits. `addr_width` then equals the number of address bits sent, and `size_known` becomes 1 and stays 1 until reset.
- R5: The probe frame is followed, inside the same busy window, by the requested read. Every non-probe frame carries exactly `addr_width` address bits, the low `addr_width` bits of `word_addr` sent MSB first. Each frame therefore has 3 + width + 16 serial clock pulses.
- R6: The 16 data bits are sampled at the end of each clock-high phase and assembled MSB first. `rd_data` takes the word in the cycle `done` is 1 and holds it until the next `done`.
- R7: `busy` rises at the clock edge that accepts `start` and falls at the edge that raises `done`, and `done` is 1 for one cycle. The busy window lasts P × L cycles, where L is the phase length and P = 2 + 3 × (19 + width) per frame, counted twice for a probing read.
- R8: A `start` pulse that arrives while `busy` is 1 has no effect: the result, the frame count and the busy length are unchanged, and no read follows the current one.
- R9: The phase length is `half_div`, but at least `SYNC_STAGES` + 1 cycles. Smaller values, including 0, give the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for one read; ignored while busy |
| word_addr | input | MAX_AW | Word address; the low `addr_width` bits are used |
| half_div | input | DIV_W | Phase length in system cycles, latched at start |
| rd_data | output | DATA_W | Last word read |
| done | output | 1 | One-cycle pulse when `rd_data` is updated |
| busy | output | 1 | High from the accepted start until done |
| addr_width | output | $clog2(MAX_AW+1) | Discovered device address width |
| size_known | output | 1 | Address width has been discovered |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_cs | output | 1 | Chip select to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with `MAX_AW` = 8, `DATA_W` = 16, `DIV_W` = 6 and `SYNC_STAGES` = 1. This gives a minimum phase length of 2, so `half_div` values 0 and 1 exercise the clamp and 2 and 3 run unclamped. A behavioural memory model whose width is changed between resets covers every address width from 1 to 8, and also an absent device whose data line never goes low. Widths up to 3 get an exhaustive address sweep. Expected words, frame bit counts and busy lengths are worked out arithmetically from the width and the phase length.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

   // top-level sequencer state
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CSUP,
      ST_SHIFT,
      ST_GAP
   } uwr_state_e;

   // which field of the frame is being shifted
   typedef enum logic [1:0] {
      SEG_OP,
      SEG_AD,
      SEG_DT
   } uwr_seg_e;

   // phase inside one serial bit
   typedef enum logic [1:0] {
      PH_SET,
      PH_HI,
      PH_LO
   } uwr_phase_e;

   // start bit followed by the two read-command bits, sent MSB first
   localparam int         READ_CODE_LEN = 3;
   localparam logic [2:0] READ_CODE     = 3'b110;

endpackage

// File: rtl/uwr_phase_timer.sv
module uwr_phase_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] len,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   // tick marks the last cycle of a phase of len cycles
   assign tick = run && (cnt_q == len - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/uwr_rx_shift.sv
module uwr_rx_shift #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din_raw,
   input  logic              shift_en,
   output logic              din_s,
   output logic [DATA_W-1:0] word
);

   logic [DATA_W-1:0] word_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign din_s = din_raw;
      end else if (SYNC_STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= din_raw;
         end
         assign din_s = s_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[SYNC_STAGES-2:0], din_raw};
         end
         assign din_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (shift_en) begin
         word_q <= {word_q[DATA_W-2:0], din_s};
      end
   end

   assign word = word_q;

endmodule

// File: rtl/uwr_ctrl.sv
module uwr_ctrl
   import uwr_pkg::*;
#(
   parameter int MAX_AW = 8,
   parameter int DATA_W = 16,
   parameter int DIV_W  = 8,
   localparam int AWW   = $clog2(MAX_AW + 1),
   localparam int CMAX  = (DATA_W > MAX_AW) ? DATA_W : MAX_AW,
   localparam int CW    = ($clog2(CMAX + 1) < 2) ? 2 : $clog2(CMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MAX_AW-1:0] word_addr,
   input  logic [DIV_W-1:0]  len_in,
   input  logic              tick,
   input  logic              din_s,
   input  logic [DATA_W-1:0] rx_word,
   output logic              run,
   output logic [DIV_W-1:0]  len_q,
   output logic              shift_en,
   output logic              sk,
   output logic              cs,
   output logic              di,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [AWW-1:0]    addr_width,
   output logic              size_known
);

   uwr_state_e        st_q;
   uwr_seg_e          seg_q;
   uwr_phase_e        ph_q;
   logic [CW-1:0]     bcnt_q;
   logic [MAX_AW-1:0] addr_q;
   logic              probe_q;
   logic [AWW-1:0]    aw_q;
   logic              known_q;
   logic              sk_q, cs_q, di_q, done_q;
   logic [DATA_W-1:0] rd_q;

   function automatic logic code_bit(input logic [CW-1:0] idx);
      logic [READ_CODE_LEN-1:0] t;
      t = READ_CODE >> idx;
      return t[0];
   endfunction

   function automatic logic addr_bit(input logic [MAX_AW-1:0] a, input logic [CW-1:0] idx);
      logic [MAX_AW-1:0] t;
      t = a >> idx;
      return t[0];
   endfunction

   assign run      = (st_q != ST_IDLE);
   assign busy     = run;
   assign shift_en = (st_q == ST_SHIFT) && tick && (ph_q == PH_HI) && (seg_q == SEG_DT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         seg_q   <= SEG_OP;
         ph_q    <= PH_SET;
         bcnt_q  <= '0;
         addr_q  <= '0;
         len_q   <= '0;
         probe_q <= 1'b0;
         aw_q    <= '0;
         known_q <= 1'b0;
         sk_q    <= 1'b0;
         cs_q    <= 1'b0;
         di_q    <= 1'b0;
         done_q  <= 1'b0;
         rd_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q  <= word_addr;
                  len_q   <= len_in;
                  probe_q <= !known_q;
                  cs_q    <= 1'b1;
                  sk_q    <= 1'b0;
                  di_q    <= 1'b0;
                  st_q    <= ST_CSUP;
               end
            end
            ST_CSUP: begin
               if (tick) begin
                  st_q   <= ST_SHIFT;
                  seg_q  <= SEG_OP;
                  ph_q   <= PH_SET;
                  bcnt_q <= CW'(READ_CODE_LEN - 1);
                  di_q   <= code_bit(CW'(READ_CODE_LEN - 1));
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  case (ph_q)
                     PH_SET: begin
                        sk_q <= 1'b1;
                        ph_q <= PH_HI;
                     end
                     PH_HI: begin
                        sk_q <= 1'b0;
                        ph_q <= PH_LO;
                     end
                     PH_LO: begin
                        ph_q <= PH_SET;
                        case (seg_q)
                           SEG_OP: begin
                              if (bcnt_q != '0) begin
                                 bcnt_q <= bcnt_q - CW'(1);
                                 di_q   <= code_bit(bcnt_q - CW'(1));
                              end else if (probe_q) begin
                                 seg_q  <= SEG_AD;
                                 bcnt_q <= CW'(MAX_AW - 1);
                                 di_q   <= 1'b0;
                              end else begin
                                 seg_q  <= SEG_AD;
                                 bcnt_q <= CW'(aw_q) - CW'(1);
                                 di_q   <= addr_bit(addr_q, CW'(aw_q) - CW'(1));
                              end
                           end
                           SEG_AD: begin
                              if (probe_q && (!din_s || bcnt_q == '0)) begin
                                 aw_q    <= AWW'(MAX_AW) - AWW'(bcnt_q);
                                 known_q <= 1'b1;
                                 seg_q   <= SEG_DT;
                                 bcnt_q  <= CW'(DATA_W - 1);
                                 di_q    <= 1'b0;
                              end else if (!probe_q && bcnt_q == '0) begin
                                 seg_q   <= SEG_DT;
                                 bcnt_q  <= CW'(DATA_W - 1);
                                 di_q    <= 1'b0;
                              end else begin
                                 bcnt_q  <= bcnt_q - CW'(1);
                                 di_q    <= probe_q ? 1'b0 : addr_bit(addr_q, bcnt_q - CW'(1));
                              end
                           end
                           default: begin
                              if (bcnt_q == '0) begin
                                 cs_q <= 1'b0;
                                 di_q <= 1'b0;
                                 st_q <= ST_GAP;
                              end else begin
                                 bcnt_q <= bcnt_q - CW'(1);
                              end
                           end
                        endcase
                     end
                     default: ph_q <= PH_SET;
                  endcase
               end
            end
            default: begin
               if (tick) begin
                  if (probe_q) begin
                     probe_q <= 1'b0;
                     cs_q    <= 1'b1;
                     st_q    <= ST_CSUP;
                  end else begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                     rd_q   <= rx_word;
                  end
               end
            end
         endcase
      end
   end

   assign sk         = sk_q;
   assign cs         = cs_q;
   assign di         = di_q;
   assign done       = done_q;
   assign rd_data    = rd_q;
   assign addr_width = aw_q;
   assign size_known = known_q;

endmodule

// File: rtl/uwire_rom_reader.sv
module uwire_rom_reader #(
   parameter int MAX_AW      = 8,
   parameter int DATA_W      = 16,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [MAX_AW-1:0]            word_addr,
   input  logic [DIV_W-1:0]             half_div,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         done,
   output logic                         busy,
   output logic [$clog2(MAX_AW+1)-1:0]  addr_width,
   output logic                         size_known,
   output logic                         ee_sk,
   output logic                         ee_cs,
   output logic                         ee_di,
   input  logic                         ee_do
);

   localparam int MIN_DIV = SYNC_STAGES + 1;

   initial begin : prm_chk
      assert (MAX_AW >= 1 && MAX_AW <= 15) else $error("MAX_AW out of range");
      assert (DATA_W >= 2) else $error("DATA_W too small");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 3) else $error("SYNC_STAGES out of range");
      assert (DIV_W >= 1 && MIN_DIV < (1 << DIV_W)) else $error("DIV_W cannot hold minimum phase");
   end

   logic [DIV_W-1:0]  len_in, len_q;
   logic              run, tick, din_s, shift_en;
   logic [DATA_W-1:0] rx_word;

   // phase length clamp: the sampled data must cross the synchronizer inside one high phase
   assign len_in = (half_div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : half_div;

   uwr_phase_timer #(.DIV_W(DIV_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .len   (len_q),
      .tick  (tick)
   );

   uwr_rx_shift #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .din_raw  (ee_do),
      .shift_en (shift_en),
      .din_s    (din_s),
      .word     (rx_word)
   );

   uwr_ctrl #(.MAX_AW(MAX_AW), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .word_addr  (word_addr),
      .len_in     (len_in),
      .tick       (tick),
      .din_s      (din_s),
      .rx_word    (rx_word),
      .run        (run),
      .len_q      (len_q),
      .shift_en   (shift_en),
      .sk         (ee_sk),
      .cs         (ee_cs),
      .di         (ee_di),
      .busy       (busy),
      .done       (done),
      .rd_data    (rd_data),
      .addr_width (addr_width),
      .size_known (size_known)
   );

endmodule

// File: rtl/uwr_chk.sv
module uwr_chk #(
   parameter int MAX_AW = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        busy,
   input logic                        done,
   input logic                        size_known,
   input logic [$clog2(MAX_AW+1)-1:0] addr_width,
   input logic                        ee_sk,
   input logic                        ee_cs,
   input logic                        ee_di
);

   // R2
   cs_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ee_cs);

   // R2
   frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_cs) |-> (!ee_sk && !ee_di));

   // R3
   di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> $stable(ee_di));

   // R3
   sk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs);

   // R4
   known_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_known |=> size_known);

   // R4
   width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_known |-> (addr_width >= 1 && 32'(addr_width) <= MAX_AW));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind uwire_rom_reader uwr_chk #(.MAX_AW(MAX_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .size_known (size_known),
   .addr_width (addr_width),
   .ee_sk      (ee_sk),
   .ee_cs      (ee_cs),
   .ee_di      (ee_di)
);

// File: tb/uwire_rom_reader_bench.sv
module uwire_rom_reader_bench;

   localparam int MAX_AW  = 8;
   localparam int DATA_W  = 16;
   localparam int DIV_W   = 6;
   localparam int SYNC    = 1;
   localparam int MIN_DIV = SYNC + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [MAX_AW-1:0] word_addr = '0;
   logic [DIV_W-1:0]  half_div = 6'd3;
   logic [DATA_W-1:0] rd_data;
   logic              done, busy, size_known;
   logic [3:0]        addr_width;
   logic              ee_sk, ee_cs, ee_di;
   logic              ee_do = 1'b1;

   always #10 clk = ~clk;

   uwire_rom_reader #(.MAX_AW(MAX_AW), .DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC))
   u_uwire_rom_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .word_addr(word_addr), .half_div(half_div),
      .rd_data(rd_data), .done(done), .busy(busy), .addr_width(addr_width),
      .size_known(size_known), .ee_sk(ee_sk), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do(ee_do)
   );

   int checks = 0;
   int errors = 0;
   int dev_w  = 8;          // 0 = no device, data line stays high
   bit known_seen = 1'b0;

   // memory model and line monitors, all evaluated on the falling clock edge
   int          nbit = 0;
   logic [2:0]  m_op = '0;
   logic [15:0] m_ad = '0;
   logic [15:0] m_word = '0;
   int          frames = 0;
   int          last_nbit = 0;
   logic [2:0]  last_op = '0;
   logic [15:0] last_ad = '0;
   logic [15:0] prev_ad = '0;
   logic        p_cs = 1'b0, p_sk = 1'b0, p_di = 1'b0;
   int          sk_run = 0, cur_len = 2;
   int          sk_bad = 0, di_bad = 0, frame_bad = 0;

   function automatic logic [15:0] wval(input int w, input int a);
      return 16'((a * 40503 + w * 4099 + 16'h1D2B) ^ (a << 7));
   endfunction

   always @(negedge clk) begin
      if (ee_cs && !p_cs) begin
         nbit = 0; m_op = '0; m_ad = '0; ee_do = 1'b1;
      end
      if (!ee_cs && p_cs) begin
         ee_do = 1'b1;
         frames++;
         last_nbit = nbit;
         last_op = m_op;
         prev_ad = last_ad;
         last_ad = m_ad;
         if (ee_sk || ee_di) frame_bad++;
      end
      if (ee_cs && ee_sk && !p_sk) begin
         if (nbit < 3) begin
            m_op = {m_op[1:0], ee_di};
         end else if (nbit < 3 + dev_w) begin
            m_ad = {m_ad[14:0], ee_di};
            if (nbit == 2 + dev_w) begin
               ee_do = 1'b0;
               m_word = wval(dev_w, int'(m_ad));
            end
         end else if (dev_w != 0 && nbit < 19 + dev_w) begin
            ee_do = m_word[18 + dev_w - nbit];
         end else begin
            ee_do = 1'b1;
         end
         if (dev_w == 0) ee_do = 1'b1;
         nbit++;
      end
      if (ee_sk) begin
         sk_run++;
      end else if (p_sk) begin
         if (sk_run != cur_len) sk_bad++;
         sk_run = 0;
      end
      if (ee_sk && ee_di != p_di) di_bad++;
      p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk({ee_cs, ee_sk, ee_di, busy, done, size_known} == 6'b0, "R1 lines in reset",
          {ee_cs, ee_sk, ee_di, busy, done, size_known}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ee_cs, ee_sk, ee_di, busy, done, size_known} == 6'b0 && addr_width == 0,
          "R1 state after reset", {addr_width, ee_cs, ee_sk, ee_di, busy, done, size_known}, 0);
      known_seen = 1'b0;
   endtask

   task automatic do_read(input int a, input int dv, input bit poke);
      int eff = (dv < MIN_DIV) ? MIN_DIV : dv;
      int wd = (dev_w == 0) ? 8 : dev_w;
      int mask = (1 << wd) - 1;
      bit probe = !known_seen;
      int per_frame = 2 + 3 * (19 + wd);
      int exp_cyc = (probe ? 2 : 1) * per_frame * eff;
      logic [15:0] exp_d = (dev_w == 0) ? 16'hFFFF : wval(dev_w, a & mask);
      int f0 = frames;
      int sb0 = sk_bad;
      int db0 = di_bad;
      int fb0 = frame_bad;
      int bc = 0;
      cur_len = eff;
      word_addr = MAX_AW'(a);
      half_div = DIV_W'(dv);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy && bc < 20000) begin
         bc++;
         if (poke && bc == 25) begin
            word_addr = MAX_AW'(a ^ 3);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(bc == exp_cyc, "R7 R9 busy length", bc, exp_cyc);
      chk(done == 1'b1, "R7 done at busy end", done, 1);
      chk(rd_data == exp_d, "R6 read data", rd_data, exp_d);
      chk(int'(addr_width) == wd, "R4 discovered width", addr_width, wd);
      chk(size_known == 1'b1, "R4 size known", size_known, 1);
      chk(frames - f0 == (probe ? 2 : 1), "R5 frames per read", frames - f0, probe ? 2 : 1);
      chk(last_op == 3'b110, "R2 command bits", last_op, 3'b110);
      chk(last_nbit == 19 + wd, "R5 clock pulses per frame", last_nbit, 19 + wd);
      if (dev_w != 0) begin
         chk(int'(last_ad) == (a & mask), "R5 address bits", last_ad, a & mask);
         if (probe) chk(prev_ad == 16'h0, "R4 probe address zero", prev_ad, 0);
      end
      chk(sk_bad == sb0 && di_bad == db0, "R3 bit phases", (sk_bad - sb0) + (di_bad - db0), 0);
      chk(frame_bad == fb0, "R2 frame close", frame_bad - fb0, 0);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);
      chk(rd_data == exp_d, "R6 data held", rd_data, exp_d);
      if (poke) begin
         repeat (3) @(negedge clk);
         chk(busy == 1'b0 && frames == f0 + (probe ? 2 : 1), "R8 start while busy ignored",
             frames - f0, probe ? 2 : 1);
      end
      known_seen = 1'b1;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int w = 0; w <= 8; w++) begin
         int wd;
         int n;
         dev_w = w;
         do_reset();
         wd = (w == 0) ? 8 : w;
         n = 1 << wd;
         if (wd <= 3) begin
            for (int a = 0; a < n; a++) do_read(a, a % 4, a == 1);
         end else begin
            for (int k = 0; k < 5; k++) do_read((k * 53 + 7) % n, k % 4, k == 2);
            do_read(n - 1, 3, 1'b0);
            do_read(0, 0, 1'b0);
         end
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule